// File: doc/BRIEF.md
# Prefixed Opcode Length Predecoder

This block watches the instruction byte stream of an 8-bit processor whose opcode space has a base page and two alternate pages reached through the prefix bytes 0x10 and 0x11. For every instruction it emits one descriptor. The descriptor gives the total byte length of the instruction, counting the prefix. It also gives the page on which the opcode was decoded, the addressing class, and a flag for opcodes that the page does not define. A fetch unit uses the length to know how many bytes make up the current instruction before it hands them on. The block executes nothing.

Bytes arrive on a valid/ready handshake, one byte per accepted cycle. The block consumes the whole instruction: the prefix, the opcode, the indexed postbyte when there is one, and the remaining operand bytes. Operand bytes are only counted and never decoded. A descriptor is issued as soon as the length is known. That is the cycle after the opcode is accepted, or for indexed instructions the cycle after the postbyte is accepted. The descriptor is held on a valid/ready output until it is taken. While a descriptor is pending, the input is stalled.

Top module: `opcode_predecoder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: On the base page, opcode rows 0x8_/0xC_ are immediate (class 1), rows 0x9_/0xD_ are direct (class 2, length 2), rows 0xA_/0xE_ are indexed (class 3), and rows 0xB_/0xF_ are extended (class 4, length 3). Page codes are 0 for base, 1 after prefix 0x10, and 2 after prefix 0x11.
- R3: Immediate opcodes 0x83, 0x8C, 0x8E, 0xC3, 0xCC and 0xCE carry a 2-byte operand. Other base-page immediates carry 1 byte. The immediate opcodes defined on the alternate pages all carry 2 bytes.
- R4: Relative class is code 5. Base-page 0x20–0x2F and 0x8D have length 2. Base-page 0x16 and 0x17 have length 3. Opcodes 0x21–0x2F after prefix 0x10 have length 4.
- R5: 0x34–0x37, 0x1E and 0x1F take one register-select postbyte (class 6, length 2). 0x1A and 0x1C take one immediate byte (class 1, length 2).
- R6: Indexed length is prefix + opcode + postbyte + extra. Extra is 1 when the postbyte has bit 7 set and low nibble 8 or C. Extra is 2 when bit 7 is set and the low nibble is 9, D or F. Extra is 0 otherwise.
- R7: A prefix applies to the next byte only. The reported length includes it, and the following instruction decodes on page 0.
- R8: After prefix 0x11, only 0x83, 0x8C, 0x93, 0x9C, 0xA3, 0xAC, 0xB3, 0xBC and 0x3F are defined. Every other opcode is illegal.
- R9: An undefined opcode on any page gives out_illegal = 1, length 1, class 0 and the current page. The next byte starts a new instruction on page 0.
- R10: Operand bytes are consumed without being decoded, even when they equal a prefix value. Exactly one descriptor is issued per instruction.
- R11: While out_valid is 1 and out_ready is 0, the descriptor stays stable and in_ready is 0.
- R12: Inherent opcodes (class 0) have length 1, or 2 when prefixed. Examples are 0x12 and 0x4F, and 0x3F after either prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | Descriptor present |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_len | output | LEN_W | Total instruction length in bytes |
| out_page | output | 2 | Decode page: 0 base, 1 prefix 0x10, 2 prefix 0x11 |
| out_class | output | 3 | Addressing class code |
| out_illegal | output | 1 | Opcode undefined on its page |

## Verification
The stimulus is a sequence of whole instructions that covers each opcode row on each page. It is built so that a wrong row-to-mode mapping, a wrong short or long operand choice, or a missing prefix count each shows up as a different length or class. Indexed postbytes cover every length variant, including low nibble 8 with bit 7 clear, which tells the bit-7 qualification apart from the nibble match. Operand bytes equal to 0x10 and 0x11, and an illegal prefix-after-prefix, check that decode restarts cleanly. A stalled consumer checks that the descriptor holds and the input stops.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_PAGES = 3;
    localparam logic [BYTE_W-1:0] PFX_ALT1 = 8'h10;
    localparam logic [BYTE_W-1:0] PFX_ALT2 = 8'h11;

    typedef enum logic [2:0] {
        CL_INH = 3'd0,
        CL_IMM = 3'd1,
        CL_DIR = 3'd2,
        CL_IDX = 3'd3,
        CL_EXT = 3'd4,
        CL_REL = 3'd5,
        CL_REG = 3'd6
    } cls_e;

    typedef enum logic [1:0] {
        PG_BASE = 2'd0,
        PG_ALT1 = 2'd1,
        PG_ALT2 = 2'd2
    } page_e;

    typedef struct packed {
        cls_e       cls;
        logic       ill;
        logic [1:0] opnd;   // operand bytes after opcode (indexed: excludes postbyte)
    } opdec_t;

    function automatic opdec_t mk(cls_e c, logic [1:0] n);
        opdec_t d;
        d.cls  = c;
        d.ill  = 1'b0;
        d.opnd = n;
        return d;
    endfunction

    function automatic opdec_t bad();
        opdec_t d;
        d.cls  = CL_INH;
        d.ill  = 1'b1;
        d.opnd = 2'd0;
        return d;
    endfunction

    // Mode for opcode rows 0x8..0xF, selected by the row's low two bits.
    function automatic opdec_t row_mode(logic [3:0] hi, logic wide_imm);
        case (hi[1:0])
            2'b00:   return mk(CL_IMM, wide_imm ? 2'd2 : 2'd1);
            2'b01:   return mk(CL_DIR, 2'd1);
            2'b10:   return mk(CL_IDX, 2'd0);
            default: return mk(CL_EXT, 2'd2);
        endcase
    endfunction

    function automatic logic odd_hole(logic [3:0] lo);
        return (lo == 4'h1) || (lo == 4'h2) || (lo == 4'h5) || (lo == 4'hB);
    endfunction

    function automatic opdec_t dec_base(logic [BYTE_W-1:0] op);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = op[7:4];
        lo = op[3:0];
        case (hi)
            4'h0: return odd_hole(lo) ? bad() : mk(CL_DIR, 2'd1);
            4'h1: begin
                case (lo)
                    4'h2, 4'h3, 4'h9, 4'hD: return mk(CL_INH, 2'd0);
                    4'h6, 4'h7:             return mk(CL_REL, 2'd2);
                    4'hA, 4'hC:             return mk(CL_IMM, 2'd1);
                    4'hE, 4'hF:             return mk(CL_REG, 2'd1);
                    default:                return bad();
                endcase
            end
            4'h2: return mk(CL_REL, 2'd1);
            4'h3: begin
                case (lo)
                    4'h0, 4'h1, 4'h2, 4'h3:        return mk(CL_IDX, 2'd0);
                    4'h4, 4'h5, 4'h6, 4'h7:        return mk(CL_REG, 2'd1);
                    4'hC:                          return mk(CL_IMM, 2'd1);
                    4'h9, 4'hA, 4'hB, 4'hD, 4'hF:  return mk(CL_INH, 2'd0);
                    default:                       return bad();
                endcase
            end
            4'h4, 4'h5: return (odd_hole(lo) || lo == 4'hE) ? bad() : mk(CL_INH, 2'd0);
            4'h6: return odd_hole(lo) ? bad() : mk(CL_IDX, 2'd0);
            4'h7: return odd_hole(lo) ? bad() : mk(CL_EXT, 2'd2);
            4'h8, 4'hC: begin
                if (op == 8'h8D)                         return mk(CL_REL, 2'd1);
                if (lo == 4'h7 || lo == 4'hF || op == 8'hCD) return bad();
                return row_mode(hi, (lo == 4'h3) || (lo == 4'hC) || (lo == 4'hE));
            end
            default: return row_mode(hi, 1'b0);
        endcase
    endfunction

    function automatic opdec_t dec_alt1(logic [BYTE_W-1:0] op);
        logic [3:0] hi;
        logic [3:0] lo;
        logic       ok;
        hi = op[7:4];
        lo = op[3:0];
        if (hi == 4'h2 && lo != 4'h0) return mk(CL_REL, 2'd2);
        if (op == 8'h3F)              return mk(CL_INH, 2'd0);
        if (!hi[3])                   return bad();
        if (!hi[2])
            ok = (lo == 4'h3) || (lo == 4'hC) || (lo == 4'hE) || (lo == 4'hF && hi != 4'h8);
        else
            ok = (lo == 4'hE) || (lo == 4'hF && hi != 4'hC);
        return ok ? row_mode(hi, 1'b1) : bad();
    endfunction

    function automatic opdec_t dec_alt2(logic [BYTE_W-1:0] op);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = op[7:4];
        lo = op[3:0];
        if (op == 8'h3F) return mk(CL_INH, 2'd0);
        if (hi[3] && !hi[2] && (lo == 4'h3 || lo == 4'hC)) return row_mode(hi, 1'b1);
        return bad();
    endfunction

    // Extra bytes following an indexed postbyte.
    function automatic logic [1:0] idx_extra(logic [BYTE_W-1:0] pb);
        if (!pb[7]) return 2'd0;
        case (pb[3:0])
            4'h8, 4'hC:       return 2'd1;
            4'h9, 4'hD, 4'hF: return 2'd2;
            default:          return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/pdec_opcode_table.sv
module pdec_opcode_table
    import pdec_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    input  page_e             page,
    output opdec_t            dec
);
    opdec_t page_dec [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        if (g == 0) begin : g_base
            assign page_dec[g] = dec_base(op);
        end else if (g == 1) begin : g_alt1
            assign page_dec[g] = dec_alt1(op);
        end else begin : g_alt2
            assign page_dec[g] = dec_alt2(op);
        end
    end

    always_comb begin
        dec = bad();
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (page == page_e'(p)) dec = page_dec[p];
        end
    end
endmodule

// File: rtl/pdec_postbyte.sv
module pdec_postbyte
    import pdec_pkg::*;
(
    input  logic [BYTE_W-1:0] pb,
    output logic [1:0]        extra
);
    assign extra = idx_extra(pb);
endmodule

// File: rtl/pdec_sequencer.sv
module pdec_sequencer
    import pdec_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [BYTE_W-1:0] in_byte,
    input  opdec_t            dec,
    input  logic [1:0]        extra,
    output page_e             dec_page,
    output logic              emit,
    output logic [LEN_W-1:0]  e_len,
    output page_e             e_page,
    output cls_e              e_cls,
    output logic              e_ill
);
    typedef enum logic [1:0] {S_IDLE, S_OPC, S_POST, S_SKIP} st_e;

    st_e        st_q, st_n;
    page_e      page_q, page_n;
    logic [1:0] skip_q, skip_n;
    int         pfx;

    assign dec_page = page_q;
    assign pfx      = (page_q != PG_BASE) ? 1 : 0;

    always_comb begin
        st_n   = st_q;
        page_n = page_q;
        skip_n = skip_q;
        emit   = 1'b0;
        e_len  = '0;
        e_page = page_q;
        e_cls  = dec.cls;
        e_ill  = 1'b0;
        if (accept) begin
            unique case (st_q)
                S_IDLE, S_OPC: begin
                    if (st_q == S_IDLE && in_byte == PFX_ALT1) begin
                        page_n = PG_ALT1;
                        st_n   = S_OPC;
                    end else if (st_q == S_IDLE && in_byte == PFX_ALT2) begin
                        page_n = PG_ALT2;
                        st_n   = S_OPC;
                    end else if (dec.ill) begin
                        emit   = 1'b1;
                        e_len  = LEN_W'(1);
                        e_cls  = CL_INH;
                        e_ill  = 1'b1;
                        st_n   = S_IDLE;
                        page_n = PG_BASE;
                    end else if (dec.cls == CL_IDX) begin
                        st_n = S_POST;
                    end else begin
                        emit   = 1'b1;
                        e_len  = LEN_W'(pfx + 1 + int'(dec.opnd));
                        skip_n = dec.opnd;
                        st_n   = (dec.opnd != 2'd0) ? S_SKIP : S_IDLE;
                        page_n = PG_BASE;
                    end
                end
                S_POST: begin
                    emit   = 1'b1;
                    e_len  = LEN_W'(pfx + 2 + int'(extra));
                    e_cls  = CL_IDX;
                    skip_n = extra;
                    st_n   = (extra != 2'd0) ? S_SKIP : S_IDLE;
                    page_n = PG_BASE;
                end
                S_SKIP: begin
                    skip_n = skip_q - 2'd1;
                    if (skip_q == 2'd1) st_n = S_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            page_q <= PG_BASE;
            skip_q <= 2'd0;
        end else begin
            st_q   <= st_n;
            page_q <= page_n;
            skip_q <= skip_n;
        end
    end
endmodule

// File: rtl/pdec_outreg.sv
module pdec_outreg
    import pdec_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] d_len,
    input  page_e            d_page,
    input  cls_e             d_cls,
    input  logic             d_ill,
    input  logic             take,
    output logic             q_valid,
    output logic [LEN_W-1:0] q_len,
    output page_e            q_page,
    output cls_e             q_cls,
    output logic             q_ill
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_len   <= '0;
            q_page  <= PG_BASE;
            q_cls   <= CL_INH;
            q_ill   <= 1'b0;
        end else if (load) begin
            q_valid <= 1'b1;
            q_len   <= d_len;
            q_page  <= d_page;
            q_cls   <= d_cls;
            q_ill   <= d_ill;
        end else if (take) begin
            q_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/opcode_predecoder.sv
module opcode_predecoder
    import pdec_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [LEN_W-1:0] out_len,
    output logic [1:0]       out_page,
    output logic [2:0]       out_class,
    output logic             out_illegal
);
    localparam int MAX_LEN = 5;
    initial if (LEN_W < $clog2(MAX_LEN + 1)) $error("LEN_W too small for longest instruction");

    logic             accept;
    opdec_t           dec;
    logic [1:0]       extra;
    page_e            dec_page;
    logic             emit;
    logic [LEN_W-1:0] e_len;
    page_e            e_page;
    cls_e             e_cls;
    logic             e_ill;
    page_e            q_page;
    cls_e             q_cls;

    assign in_ready = !out_valid;
    assign accept   = in_valid && in_ready;

    pdec_opcode_table u_table (
        .op   (in_byte),
        .page (dec_page),
        .dec  (dec)
    );

    pdec_postbyte u_post (
        .pb    (in_byte),
        .extra (extra)
    );

    pdec_sequencer #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .in_byte  (in_byte),
        .dec      (dec),
        .extra    (extra),
        .dec_page (dec_page),
        .emit     (emit),
        .e_len    (e_len),
        .e_page   (e_page),
        .e_cls    (e_cls),
        .e_ill    (e_ill)
    );

    pdec_outreg #(.LEN_W(LEN_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (emit),
        .d_len   (e_len),
        .d_page  (e_page),
        .d_cls   (e_cls),
        .d_ill   (e_ill),
        .take    (out_ready),
        .q_valid (out_valid),
        .q_len   (out_len),
        .q_page  (q_page),
        .q_cls   (q_cls),
        .q_ill   (out_illegal)
    );

    assign out_page  = q_page;
    assign out_class = q_cls;
endmodule

// File: rtl/pdec_checker.sv
module pdec_checker #(
    parameter int LEN_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       in_byte,
    input logic             out_valid,
    input logic             out_ready,
    input logic [LEN_W-1:0] out_len,
    input logic [1:0]       out_page,
    input logic [2:0]       out_class,
    input logic             out_illegal
);
    logic past_rst = 1'b0;
    always_ff @(posedge clk) past_rst <= rst;

    // R1: first cycle after reset shows no descriptor
    always_ff @(posedge clk) begin
        if (past_rst && !rst) a_r1_idle_after_reset: assert (!out_valid && in_ready);
    end

    // R11: a stalled descriptor holds its fields
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_page)
                                    && $stable(out_class) && $stable(out_illegal));

    // R9: illegal descriptors are one byte of inherent class
    a_r9_illegal_len: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_illegal |-> out_len == LEN_W'(1) && out_class == 3'd0);

    // R6: length stays within one to five bytes
    a_r6_len_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_len >= LEN_W'(1) && out_len <= LEN_W'(5));

    // R4: relative instructions are two to four bytes
    a_r4_rel_len: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_class == 3'd5 |-> out_len >= LEN_W'(2) && out_len <= LEN_W'(4));

    // R7: a prefixed legal instruction counts its prefix
    a_r7_prefix_len: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_illegal && out_page != 2'd0 |-> out_len >= LEN_W'(2));

    // R8: legal third-page opcodes are never relative, indexed-extended only up to five
    a_r8_alt2_class: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_illegal && out_page == 2'd2 |-> out_class != 3'd5 && out_class != 3'd6);

    // R2: page code 3 never appears
    a_r2_page_code: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_page != 2'd3);

    // R11: nothing is taken while a descriptor waits
    a_r11_stall: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> !in_ready);
endmodule

bind opcode_predecoder pdec_checker #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_byte     (in_byte),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_len     (out_len),
    .out_page    (out_page),
    .out_class   (out_class),
    .out_illegal (out_illegal)
);

// File: tb/sim_opcode_predecoder.sv
`timescale 1ns/1ps
module sim_opcode_predecoder;
    localparam int C_INH = 0, C_IMM = 1, C_DIR = 2, C_IDX = 3, C_EXT = 4, C_REL = 5, C_REG = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [2:0] out_len;
    logic [1:0] out_page;
    logic [2:0] out_class;
    logic       out_illegal;

    int checks = 0;
    int fails  = 0;
    logic [8:0] seen [$];   // {illegal, class, page, len} packed below

    always #2.5 clk = ~clk;

    opcode_predecoder u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len), .out_page(out_page),
        .out_class(out_class), .out_illegal(out_illegal)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) seen.push_back({out_illegal, out_class, out_page, out_len});
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // bytes: byte0 in [39:32]
    task automatic instr(input string req, input int n, input logic [39:0] bytes,
                         input int len, input int page, input int cls, input int ill);
        logic [8:0] d;
        for (int i = 0; i < n; i++) push(bytes[39-8*i -: 8]);
        repeat (3) @(negedge clk);
        check(req, "descriptor count", seen.size(), 1);
        if (seen.size() > 0) begin
            d = seen.pop_front();
            check(req, "length",  int'(d[2:0]), len);
            check(req, "page",    int'(d[4:3]), page);
            check(req, "class",   int'(d[7:5]), cls);
            check(req, "illegal", int'(d[8]),   ill);
        end
        seen.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "in_ready",  int'(in_ready),  1);
    endtask

    task automatic t_inherent();
        instr("R12", 1, 40'h12_00000000, 1, 0, C_INH, 0);
        instr("R12", 1, 40'h4F_00000000, 1, 0, C_INH, 0);
        instr("R12", 2, 40'h10_3F_000000, 2, 1, C_INH, 0);
    endtask

    task automatic t_rows();
        instr("R2", 2, 40'h96_40_000000, 2, 0, C_DIR, 0);
        instr("R2", 3, 40'hB6_12_34_0000, 3, 0, C_EXT, 0);
        instr("R2", 2, 40'h86_05_000000, 2, 0, C_IMM, 0);
        instr("R2", 2, 40'hD7_00_000000, 2, 0, C_DIR, 0);
        instr("R2", 3, 40'hF7_AA_BB_0000, 3, 0, C_EXT, 0);
    endtask

    task automatic t_imm16();
        instr("R3", 3, 40'hCC_12_34_0000, 3, 0, C_IMM, 0);
        instr("R3", 3, 40'h83_00_01_0000, 3, 0, C_IMM, 0);
        instr("R3", 3, 40'h8E_FF_FF_0000, 3, 0, C_IMM, 0);
        instr("R3", 4, 40'h10_CE_00_00_00, 4, 1, C_IMM, 0);
    endtask

    task automatic t_branch();
        instr("R4", 2, 40'h20_FE_000000, 2, 0, C_REL, 0);
        instr("R4", 2, 40'h8D_10_000000, 2, 0, C_REL, 0);
        instr("R4", 3, 40'h17_00_01_0000, 3, 0, C_REL, 0);
        instr("R4", 4, 40'h10_26_FF_EE_00, 4, 1, C_REL, 0);
    endtask

    task automatic t_postgroup();
        instr("R5", 2, 40'h34_16_000000, 2, 0, C_REG, 0);
        instr("R5", 2, 40'h1F_89_000000, 2, 0, C_REG, 0);
        instr("R5", 2, 40'h1A_50_000000, 2, 0, C_IMM, 0);
    endtask

    task automatic t_indexed();
        instr("R6", 2, 40'hA6_84_000000, 2, 0, C_IDX, 0);
        instr("R6", 3, 40'hA6_88_05_0000, 3, 0, C_IDX, 0);
        instr("R6", 3, 40'hA6_9C_10_0000, 3, 0, C_IDX, 0);
        instr("R6", 4, 40'hAE_89_12_34_00, 4, 0, C_IDX, 0);
        instr("R6", 4, 40'hE6_9F_12_34_00, 4, 0, C_IDX, 0);
        instr("R6", 2, 40'hA6_08_000000, 2, 0, C_IDX, 0);
        instr("R6", 4, 40'h10_AE_98_02_00, 4, 1, C_IDX, 0);
        instr("R6", 5, 40'h10_EE_99_11_22, 5, 1, C_IDX, 0);
    endtask

    task automatic t_page11();
        instr("R8", 4, 40'h11_83_12_34_00, 4, 2, C_IMM, 0);
        instr("R8", 4, 40'h11_BC_12_34_00, 4, 2, C_EXT, 0);
        instr("R8", 2, 40'h11_3F_000000, 2, 2, C_INH, 0);
        instr("R8", 2, 40'h11_86_000000, 1, 2, C_INH, 1);
        instr("R7", 1, 40'h12_00000000, 1, 0, C_INH, 0);
    endtask

    task automatic t_illegal();
        instr("R9", 1, 40'h01_00000000, 1, 0, C_INH, 1);
        instr("R9", 1, 40'h87_00000000, 1, 0, C_INH, 1);
        instr("R9", 2, 40'h10_10_000000, 1, 1, C_INH, 1);
        instr("R7", 1, 40'h4F_00000000, 1, 0, C_INH, 0);
    endtask

    task automatic t_skip_operands();
        instr("R10", 2, 40'h86_10_000000, 2, 0, C_IMM, 0);
        instr("R10", 1, 40'h12_00000000, 1, 0, C_INH, 0);
        instr("R10", 3, 40'hCC_11_10_0000, 3, 0, C_IMM, 0);
        instr("R10", 1, 40'h4F_00000000, 1, 0, C_INH, 0);
    endtask

    task automatic t_backpressure();
        @(posedge clk);
        #1 out_ready = 1'b0;
        push(8'h12);
        repeat (3) @(negedge clk);
        check("R11", "out_valid held", int'(out_valid), 1);
        check("R11", "in_ready low",   int'(in_ready),  0);
        check("R11", "length held",    int'(out_len),   1);
        @(posedge clk);
        #1 out_ready = 1'b1;
        repeat (2) @(negedge clk);
        check("R11", "taken once", seen.size(), 1);
        check("R11", "released", int'(out_valid), 0);
        seen.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_inherent();
        t_rows();
        t_imm16();
        t_branch();
        t_postgroup();
        t_indexed();
        t_page11();
        t_illegal();
        t_skip_operands();
        t_backpressure();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule